// File: doc/BRIEF.md
# Multi-Channel Digital Glitch Filter

This block cleans up four slow digital inputs before they reach edge-sensitive logic. The inputs are a capture or index input, two quadrature phases and an external timer clock. Each input is first brought into the system clock domain by a synchronizer. A channel's filtered output takes on a new level only after that level has been seen on three sampling ticks in a row. A short spike is therefore dropped, while a level that is held is passed on with a delay of a few ticks.

All four channels share one sampling tick. A prescaler divides the instruction clock by a ratio chosen with a 3-bit code, and one code stops the tick entirely. An 8-bit configuration register holds that code and one enable bit per channel. When a channel's enable is clear, the channel's output is the synchronized raw input. Reset clears the register, so after reset every channel is bypassed and the ratio is 1:1.

The configuration port is a plain write strobe with a read-back value. The signal inputs and outputs are level wires with no handshake. No valid/ready stream exists in this block, so back-pressure does not apply.

Top module: `glitch_filter_bank`

## Requirements
- R1: While reset is asserted and right after it, `cfg_rdata` reads 0x00, every filtered state is 0 and every channel is bypassed.
- R2: A cycle with `cfg_we` high stores `cfg_wdata[6:0]` into the register. From the next cycle on, `cfg_rdata` returns those bits with bit 7 always 0.
- R3: A channel whose enable is clear drives `clean_out[i]` from `raw_in[i]` through a two-flop synchronizer. An input change therefore appears at the output after two rising edges.
- R4: With its enable set, a channel's output changes only on a sampling tick, and only to a level that was sampled on three consecutive ticks. A level seen on fewer ticks is dropped.
- R5: A sample that differs from the level being counted restarts agreement at one. For example, a 1,1,0,1,1 sequence does not move a low output, and a further 1 does.
- R6: The divider code in bits 2:0 sets the tick period in instruction clocks: 000=1, 001=2, 010=4, 011=16, 100=32, 101=64, 110=128. There is no ratio of 8.
- R7: Code 111 stops all ticks. Enabled outputs keep their last filtered value whatever the inputs do.
- R8: When the divider code changes, the prescaler restarts. The first tick comes exactly one new period after the first cycle in which the new code is held in the register.
- R9: The enable bits map to channels as follows: bit 3 to channel 0 (index), bit 4 to channel 1 (phase A), bit 5 to channel 2 (phase B) and bit 6 to channel 3 (timer clock). Each enable affects only its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock; also the prescaler reference |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read-back, bit 7 always 0 |
| raw_in | input | NUM_CH | Asynchronous raw inputs |
| clean_out | output | NUM_CH | Filtered or bypassed outputs |

## Verification
The bench builds the block with its default parameters: four channels, a two-flop synchronizer and three-sample agreement. It sweeps all eight divider codes, including the hold code and the longest 1:128 ratio, and feeds each channel a pseudo-random input whose toggle rate differs from channel to channel. This means that at every ratio some channels see glitches that must be dropped and others see levels long enough to pass. All sixteen enable combinations are also visited. A cycle-level model of the requirements predicts every output on every cycle. Short directed sequences pin down the synchronizer latency and the rule that a differing sample restarts the agreement count.

// File: rtl/glf_pkg.sv
package glf_pkg;
  localparam int CFG_W     = 8;
  localparam int SEL_W     = 3;
  localparam int EN_LSB    = 3;
  localparam int MAX_RATIO = 128;
  localparam int PCNT_W    = $clog2(MAX_RATIO);
  localparam logic [SEL_W-1:0] SEL_HOLD = 3'b111;

  // Divider code to period in instruction clocks; 0 means no ticks.
  function automatic logic [PCNT_W:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [PCNT_W:0] r;
    case (code)
      3'b000:  r = 8'd1;
      3'b001:  r = 8'd2;
      3'b010:  r = 8'd4;
      3'b011:  r = 8'd16;
      3'b100:  r = 8'd32;
      3'b101:  r = 8'd64;
      3'b110:  r = 8'd128;
      default: r = 8'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/glf_prescaler.sv
module glf_prescaler
  import glf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [SEL_W-1:0]  sel_q;
  logic [PCNT_W-1:0] cnt;
  logic [PCNT_W:0]   ratio;
  logic              hold;
  logic              sel_chg;

  assign ratio   = ratio_of(sel);
  assign hold    = (sel == SEL_HOLD);
  assign sel_chg = (sel != sel_q);
  assign tick    = !sel_chg && !hold && ({1'b0, cnt} == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt   <= '0;
    end else begin
      sel_q <= sel;
      if (sel_chg || hold || tick) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
    end
  end

  // R6
  no_double_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio != 8'd1) |=> !tick);
endmodule

// File: rtl/glf_filter_chan.sv
module glf_filter_chan #(
  parameter int AGREE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic samp,
  output logic filt
);
  localparam int CW = $clog2(AGREE + 1);
  localparam logic [CW-1:0] FULL = CW'(AGREE);
  localparam logic [CW-1:0] LAST = CW'(AGREE - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          cand;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand <= 1'b0;
      run  <= '0;
      filt <= 1'b0;
    end else if (tick) begin
      if (samp != cand) begin
        cand <= samp;
        run  <= ONE;
      end else begin
        if (run != FULL) run <= run + 1'b1;
        if (run == LAST) filt <= cand;
      end
    end
  end

  // R4
  filt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> ($past(tick) && $past(samp) == filt));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt));

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && samp != cand) |=> (run == ONE));
endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank
  import glf_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int AGREE       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [NUM_CH-1:0] raw_in,
  output logic [NUM_CH-1:0] clean_out
);
  logic [CFG_W-2:0]  cfg_q;
  logic              tick;
  logic [NUM_CH-1:0] synced;
  logic [NUM_CH-1:0] filtered;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata[CFG_W-2:0];
  end

  assign cfg_rdata = {1'b0, cfg_q};

  glf_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (cfg_q[SEL_W-1:0]),
    .tick  (tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    glf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_in[i]),
      .dout  (synced[i])
    );

    glf_filter_chan #(.AGREE(AGREE)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .samp  (synced[i]),
      .filt  (filtered[i])
    );

    assign clean_out[i] = cfg_q[EN_LSB+i] ? filtered[i] : synced[i];
  end

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == {1'b0, $past(cfg_wdata[CFG_W-2:0])}));
endmodule

// File: tb/tb_glitch_filter_bank.sv
module tb_glitch_filter_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic [3:0] raw_in;
  logic [3:0] clean_out;

  always #4 clk = ~clk;

  glitch_filter_bank dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .raw_in(raw_in), .clean_out(clean_out)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // Reference model built from the requirements
  logic [6:0] m_cfg;
  logic [2:0] m_prev;
  int         m_n;
  logic [3:0] m_s1, m_s2;
  logic [2:0] m_hist [4];
  int         m_val  [4];
  logic [3:0] m_filt;
  logic       m_tick;
  logic [3:0] m_exp;

  function automatic int period(input logic [2:0] c);
    case (c)
      3'd0: return 1;   3'd1: return 2;  3'd2: return 4;  3'd3: return 16;
      3'd4: return 32;  3'd5: return 64; 3'd6: return 128;
      default: return 0;
    endcase
  endfunction

  always_comb begin
    m_tick = (m_cfg[2:0] == m_prev) && (m_cfg[2:0] != 3'b111)
             && ((m_n % period(m_cfg[2:0])) == 0);
    for (int i = 0; i < 4; i++) m_exp[i] = m_cfg[3+i] ? m_filt[i] : m_s2[i];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg <= '0; m_prev <= '0; m_n <= 0; m_s1 <= '0; m_s2 <= '0; m_filt <= '0;
      for (int i = 0; i < 4; i++) begin m_hist[i] <= '0; m_val[i] <= 0; end
    end else begin
      if (cfg_we) m_cfg <= cfg_wdata[6:0];
      m_prev <= m_cfg[2:0];
      m_n    <= (m_cfg[2:0] != m_prev) ? 1 : m_n + 1;
      m_s1   <= raw_in;
      m_s2   <= m_s1;
      if (m_tick) begin
        for (int i = 0; i < 4; i++) begin
          m_hist[i] <= {m_hist[i][1:0], m_s2[i]};
          m_val[i]  <= (m_val[i] < 3) ? m_val[i] + 1 : 3;
          if (m_val[i] >= 2 && m_hist[i][1] == m_s2[i] && m_hist[i][0] == m_s2[i])
            m_filt[i] <= m_s2[i];
        end
      end
    end
  end

  task automatic expect8(input string t, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  // Wait to the falling edge, compare outputs against the model
  task automatic step();
    @(negedge clk);
    checks++;
    if (clean_out !== m_exp) begin
      errors++;
      $display("FAIL %s: clean_out=%b expected %b", tag, clean_out, m_exp);
    end
  endtask

  task automatic rnd_drive();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (lfsr[1:0]  == 0) raw_in[0] = ~raw_in[0];
    if (lfsr[5:2]  == 0) raw_in[1] = ~raw_in[1];
    if (lfsr[12:6] == 0) raw_in[2] = ~raw_in[2];
    if (lfsr[15:6] == 0) raw_in[3] = ~raw_in[3];
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic drive_seq(input logic [3:0] v, input int n);
    raw_in = v;
    repeat (n) step();
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; raw_in = 4'b1111;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect8("R1 cfg_rdata in reset", cfg_rdata, 8'h00);
    expect8("R1 clean_out in reset", {4'h0, clean_out}, 8'h00);
    raw_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    repeat (3) step();
    expect8("R1 cfg_rdata after reset", cfg_rdata, 8'h00);

    // R2 bit 7 never stored
    write_cfg(8'hFF);
    expect8("R2 readback of FF", cfg_rdata, 8'h7F);
    write_cfg(8'h80);
    expect8("R2 readback of 80", cfg_rdata, 8'h00);

    // R3 bypass latency of two edges
    tag = "R3";
    repeat (4) step();
    raw_in = 4'b1010;
    step();
    expect8("R3 one edge after change", {4'h0, clean_out}, 8'h00);
    step();
    expect8("R3 two edges after change", {4'h0, clean_out}, 8'h0A);
    drive_seq(4'b0000, 6);

    // R4 short pulses at 1:1 are dropped, a held level passes
    write_cfg(8'h78);
    tag = "R4";
    drive_seq(4'b0000, 6);
    drive_seq(4'b1111, 2);
    drive_seq(4'b0000, 8);
    expect8("R4 two-sample pulse dropped", {4'h0, clean_out}, 8'h00);
    drive_seq(4'b1111, 8);
    expect8("R4 held level passes", {4'h0, clean_out}, 8'h0F);
    drive_seq(4'b0000, 8);

    // R5 a differing sample restarts the count
    tag = "R5";
    drive_seq(4'b0101, 2);
    drive_seq(4'b0000, 1);
    drive_seq(4'b0101, 2);
    expect8("R5 restart holds output low", {4'h0, clean_out}, 8'h00);
    drive_seq(4'b0101, 6);
    expect8("R5 third matching sample passes", {4'h0, clean_out}, 8'h05);
    drive_seq(4'b0000, 6);

    // R6 / R8 sweep every ratio with all channels enabled
    for (int c = 0; c < 7; c++) begin
      write_cfg({1'b0, 4'hF, 3'(c)});
      tag = "R8";
      for (int k = 0; k < 2500; k++) begin
        if (k == 3 * period(3'(c)) + 8) tag = "R6";
        rnd_drive();
        step();
      end
    end

    // R7 hold code freezes filtered outputs
    write_cfg(8'h7F);
    tag = "R7";
    for (int k = 0; k < 600; k++) begin
      rnd_drive();
      step();
    end

    // R9 every enable combination
    tag = "R9";
    for (int e = 0; e < 16; e++) begin
      write_cfg({1'b0, 4'(e), 3'b001});
      for (int k = 0; k < 200; k++) begin
        rnd_drive();
        step();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule